// File: doc/BRIEF.md
# Segment Register Descriptor Cache

This block holds a small bank of segment registers. Each register pairs a visible 16-bit selector with a hidden copy of a segment descriptor: a 32-bit base, a 20-bit limit, an access byte and four flag bits. A write on the load port replaces the selector and refills the hidden copy. The fill depends on the mode input at the moment the load is accepted. In real mode the block fills the hidden part itself, with fixed values. In protected mode it reads an 8-byte descriptor from a descriptor table in memory, using a simple synchronous read interface.

A translation port takes a segment number and a 32-bit offset. It returns, without a clock edge, the base plus the offset and a flag that marks an offset beyond the segment's effective limit. The hidden copy is only replaced by a new load. Clearing the mode bit therefore leaves a descriptor fetched in protected mode in use. A segment loaded with a flat descriptor keeps covering 4 GiB after the switch back to real mode, and keeps doing so until that segment register is written again.

Top module: `seg_cache`

## Requirements
- R1: After reset every segment register holds selector 0, base 0, limit 0xFFFF with byte granularity, access byte 0x93 and flags 0.
- R2: A load accepted with the mode input low sets the selector, base = selector × 16, limit 0xFFFF (byte granularity), access byte 0x93 and flags 0. The result is visible on the translation port in the cycle after the accepting edge, and busy stays low.
- R3: A load accepted with the mode input high raises busy for exactly three cycles. In the first two of these cycles it issues one read each: first at table base + index × 8, then at that address + 4. Read data is expected one cycle after the read. The cache changes on the edge where busy falls.
- R4: The fetched low dword supplies base[15:0] from bits 31:16 and limit[15:0] from bits 15:0. The high dword supplies base[31:24] from bits 31:24, the flags output (granularity, default size, bits 21:20) from bits 23:20, limit[19:16] from bits 19:16, the access byte from bits 15:8 and base[23:16] from bits 7:0.
- R5: With the granularity flag (flags bit 3) set, the effective limit is (limit << 12) | 0xFFF. A limit of 0xFFFFF then covers every 32-bit offset.
- R6: The translation output is base + offset (modulo 2^32). The violation flag is high exactly when the offset exceeds the effective limit, and the address is still produced.
- R7: Changing the mode input leaves every cached selector and descriptor unchanged.
- R8: Every accepted load refills the hidden part according to the current mode, even when the selector equals the stored one.
- R9: A protected-mode load rejects the selector if any of these holds: its index (bits 15:3) is 0, its table bit (bit 2) is 1, or index × 8 + 7 exceeds the table limit input. A rejected load pulses the error output for one cycle in the cycle after the accepting edge, issues no read and leaves the cache unchanged.
- R10: With the default parameter, only bits 23:0 of the table base input are used, so the read address has bits 31:24 equal to 0. A parameter selects the full 32 bits.
- R11: A load presented while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protMode | input | 1 | Mode select, 1 = protected |
| tableBase | input | 32 | Linear base address of the descriptor table |
| tableLimit | input | 16 | Table size in bytes minus one |
| ldValid | input | 1 | Load request |
| ldSeg | input | SEG_W | Segment register to load |
| ldSel | input | 16 | Selector value to load |
| busy | output | 1 | Descriptor fetch in progress |
| ldErr | output | 1 | One-cycle pulse for a rejected selector |
| memRdEn | output | 1 | Descriptor table read request |
| memAddr | output | 32 | Read byte address (dword aligned) |
| memRdData | input | 32 | Read data, valid the cycle after the request |
| xlSeg | input | SEG_W | Segment register used for translation |
| xlOff | input | 32 | Offset to translate |
| xlAddr | output | 32 | Linear address = base + offset |
| xlViol | output | 1 | Offset beyond the effective limit |
| xlSel | output | 16 | Selector of the translated segment |
| xlAttr | output | 8 | Access byte of the translated segment |
| xlFlags | output | 4 | Flag bits of the translated segment |

## Verification
The hardest state to reach is a real-mode segment that still reaches the top of the 4 GiB range. No single load produces it. The bench first loads a flat, page-granular descriptor in protected mode, waits for busy to fall, then clears the mode bit. Only after that does it translate offsets near 0xFFFFFFFF. A later real-mode reload with the same selector value then shows that the wide limit is dropped.

// File: rtl/seg_cache_pkg.sv
package seg_cache_pkg;

  typedef struct packed {
    logic realLoad;
    logic latchReq;
    logic captureLo;
    logic commit;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic [3:0]  flags;
    logic [7:0]  access;
  } hiddenDesc_t;

  localparam logic [7:0] REAL_ACCESS = 8'h93;

  function automatic hiddenDesc_t realModeDesc(input logic [15:0] sel);
    hiddenDesc_t d;
    d.base   = {12'h000, sel, 4'h0};
    d.limit  = 20'h0FFFF;
    d.flags  = 4'h0;
    d.access = REAL_ACCESS;
    return d;
  endfunction

  function automatic hiddenDesc_t unpackDesc(input logic [31:0] lo, input logic [31:0] hi);
    hiddenDesc_t d;
    d.base   = {hi[31:24], hi[7:0], lo[31:16]};
    d.limit  = {hi[19:16], lo[15:0]};
    d.flags  = hi[23:20];
    d.access = hi[15:8];
    return d;
  endfunction

endpackage

// File: rtl/seg_cache_ctrl.sv
module seg_cache_ctrl
  import seg_cache_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          protMode,
  input  logic          ldValid,
  input  logic [15:2]   ldSelHi,
  input  logic [15:0]   tableLimit,
  output logic          busy,
  output logic          ldErr,
  output logic          memRdEn,
  output logic          hiPhase,
  output ctrlStrobes_t  strb
);

  typedef enum logic [1:0] {S_IDLE, S_REQ_LO, S_REQ_HI, S_WAIT_HI} fetchState_t;

  fetchState_t state, stateNext;
  logic        accept;
  logic        selBad;
  logic [15:0] lastByte;

  assign lastByte = {ldSelHi[15:3], 3'b111};
  assign selBad   = (ldSelHi[15:3] == 13'd0) || ldSelHi[2] || (lastByte > tableLimit);
  assign accept   = ldValid && (state == S_IDLE);

  always_comb begin
    stateNext      = state;
    strb           = '0;
    strb.realLoad  = accept && !protMode;
    strb.latchReq  = accept && protMode && !selBad;
    strb.captureLo = (state == S_REQ_HI);
    strb.commit    = (state == S_WAIT_HI);
    case (state)
      S_IDLE:    if (strb.latchReq) stateNext = S_REQ_LO;
      S_REQ_LO:  stateNext = S_REQ_HI;
      S_REQ_HI:  stateNext = S_WAIT_HI;
      S_WAIT_HI: stateNext = S_IDLE;
      default:   stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      ldErr <= 1'b0;
    end else begin
      state <= stateNext;
      ldErr <= accept && protMode && selBad;
    end
  end

  assign busy    = (state != S_IDLE);
  assign memRdEn = (state == S_REQ_LO) || (state == S_REQ_HI);
  assign hiPhase = (state == S_REQ_HI);

endmodule

// File: rtl/seg_cache_dp.sv
module seg_cache_dp
  import seg_cache_pkg::*;
#(
  parameter int NUM_SEGS        = 4,
  parameter bit FULL_TABLE_BASE = 1'b0,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [SEG_W-1:0]   ldSeg,
  input  logic [15:0]        ldSel,
  input  logic [31:0]        tableBase,
  input  logic               hiPhase,
  output logic [31:0]        memAddr,
  input  logic [31:0]        memRdData,
  input  logic [SEG_W-1:0]   xlSeg,
  input  logic [31:0]        xlOff,
  output logic [31:0]        xlAddr,
  output logic               xlViol,
  output logic [15:0]        xlSel,
  output logic [7:0]         xlAttr,
  output logic [3:0]         xlFlags
);

  localparam logic [31:0] BASE_MASK = FULL_TABLE_BASE ? 32'hFFFF_FFFF : 32'h00FF_FFFF;

  logic [SEG_W-1:0] pendSeg;
  logic [15:0]      pendSel;
  logic [31:0]      loWord;
  logic [31:0]      descAddr;
  hiddenDesc_t      fetched;
  hiddenDesc_t      descArr [NUM_SEGS];
  logic [15:0]      selArr  [NUM_SEGS];

  // pending request: segment, selector, first dword
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSeg <= '0;
      pendSel <= '0;
      loWord  <= '0;
    end else begin
      if (strb.latchReq) begin
        pendSeg <= ldSeg;
        pendSel <= ldSel;
      end
      if (strb.captureLo) loWord <= memRdData;
    end
  end

  assign descAddr = (tableBase & BASE_MASK) + {16'h0000, pendSel[15:3], 3'b000};
  assign memAddr  = descAddr + (hiPhase ? 32'd4 : 32'd0);
  assign fetched  = unpackDesc(loWord, memRdData);

  // one register slot per segment
  for (genvar g = 0; g < NUM_SEGS; g++) begin : gSeg
    logic realHit, commitHit;
    assign realHit   = strb.realLoad && (ldSeg == SEG_W'(g));
    assign commitHit = strb.commit && (pendSeg == SEG_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        selArr[g]  <= 16'h0000;
        descArr[g] <= realModeDesc(16'h0000);
      end else if (realHit) begin
        selArr[g]  <= ldSel;
        descArr[g] <= realModeDesc(ldSel);
      end else if (commitHit) begin
        selArr[g]  <= pendSel;
        descArr[g] <= fetched;
      end
    end
  end

  // translation
  hiddenDesc_t xlDesc;
  logic [31:0] effLimit;

  assign xlDesc   = descArr[xlSeg];
  assign effLimit = xlDesc.flags[3] ? {xlDesc.limit, 12'hFFF} : {12'h000, xlDesc.limit};
  assign xlAddr   = xlDesc.base + xlOff;
  assign xlViol   = xlOff > effLimit;
  assign xlSel    = selArr[xlSeg];
  assign xlAttr   = xlDesc.access;
  assign xlFlags  = xlDesc.flags;

endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_cache_pkg::*;
#(
  parameter int NUM_SEGS        = 4,
  parameter bit FULL_TABLE_BASE = 1'b0,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             protMode,
  input  logic [31:0]      tableBase,
  input  logic [15:0]      tableLimit,
  input  logic             ldValid,
  input  logic [SEG_W-1:0] ldSeg,
  input  logic [15:0]      ldSel,
  output logic             busy,
  output logic             ldErr,
  output logic             memRdEn,
  output logic [31:0]      memAddr,
  input  logic [31:0]      memRdData,
  input  logic [SEG_W-1:0] xlSeg,
  input  logic [31:0]      xlOff,
  output logic [31:0]      xlAddr,
  output logic             xlViol,
  output logic [15:0]      xlSel,
  output logic [7:0]       xlAttr,
  output logic [3:0]       xlFlags
);

  ctrlStrobes_t strb;
  logic         hiPhase;

  seg_cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .protMode(protMode), .ldValid(ldValid),
    .ldSelHi(ldSel[15:2]), .tableLimit(tableLimit), .busy(busy),
    .ldErr(ldErr), .memRdEn(memRdEn), .hiPhase(hiPhase), .strb(strb)
  );

  seg_cache_dp #(.NUM_SEGS(NUM_SEGS), .FULL_TABLE_BASE(FULL_TABLE_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ldSeg(ldSeg), .ldSel(ldSel),
    .tableBase(tableBase), .hiPhase(hiPhase), .memAddr(memAddr),
    .memRdData(memRdData), .xlSeg(xlSeg), .xlOff(xlOff), .xlAddr(xlAddr),
    .xlViol(xlViol), .xlSel(xlSel), .xlAttr(xlAttr), .xlFlags(xlFlags)
  );

endmodule

// File: rtl/seg_cache_chk.sv
module seg_cache_chk #(
  parameter int NUM_SEGS = 4,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             protMode,
  input logic             ldValid,
  input logic [SEG_W-1:0] ldSeg,
  input logic [15:0]      ldSel,
  input logic             busy,
  input logic             ldErr,
  input logic             memRdEn,
  input logic [31:0]      memAddr,
  input logic [SEG_W-1:0] xlSeg,
  input logic [15:0]      xlSel
);

  assert_busy_three_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy ##1 busy ##1 !busy);

  assert_read_in_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> (memAddr == $past(memAddr) + 32'd4));

  assert_err_no_fetch_R9: assert property (@(posedge clk) disable iff (!rstN)
    ldErr |-> (!busy && $past(ldValid) && $past(protMode)));

  assert_real_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && !busy && !protMode && ldSeg == xlSeg)
      |=> (!$stable(xlSeg) || xlSel == $past(ldSel)));

endmodule

bind seg_cache seg_cache_chk #(.NUM_SEGS(NUM_SEGS)) u_chk (.*);

// File: tb/seg_cache_bench.sv
module seg_cache_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic protMode = 1'b0, ldValid = 1'b0;
  logic [31:0] tableBase = 32'h0000_0040;
  logic [15:0] tableLimit = 16'h001F;
  logic [1:0]  ldSeg = '0, xlSeg = '0;
  logic [15:0] ldSel = '0;
  logic [31:0] xlOff = '0, memRdData = '0;
  logic busy, ldErr, memRdEn, xlViol;
  logic [31:0] memAddr, xlAddr;
  logic [15:0] xlSel;
  logic [7:0]  xlAttr;
  logic [3:0]  xlFlags;
  logic [31:0] mem [256];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_cache u_seg_cache (.*);

  always_ff @(posedge clk) if (memRdEn) memRdData <= mem[memAddr[9:2]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [1:0] s, input logic [31:0] off);
    @(negedge clk); xlSeg = s; xlOff = off; #1;
  endtask

  task automatic loadReal(input logic [1:0] s, input logic [15:0] sel);
    @(negedge clk); protMode = 0; ldValid = 1; ldSeg = s; ldSel = sel;
    @(negedge clk); ldValid = 0;
    chk("R2 busy stays low", busy, 0);
  endtask

  // protected load: returns busy cycles and read addresses
  task automatic loadProt(input logic [1:0] s, input logic [15:0] sel,
                          output int busyCnt, output logic [31:0] a0, output logic [31:0] a1);
    int rd = 0;
    busyCnt = 0; a0 = 'x; a1 = 'x;
    @(negedge clk); protMode = 1; ldValid = 1; ldSeg = s; ldSel = sel;
    @(negedge clk); ldValid = 0;
    for (int i = 0; i < 10 && busy; i++) begin
      busyCnt++;
      if (memRdEn) begin if (rd == 0) a0 = memAddr; else a1 = memAddr; rd++; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    for (int s = 0; s < 4; s++) begin
      xlate(2'(s), 32'h1234);
      chk("R1 reset selector", xlSel, 0);
      chk("R1 reset base", xlAddr, 32'h1234);
      chk("R1 reset access", xlAttr, 8'h93);
      chk("R1 reset flags", xlFlags, 0);
      xlate(2'(s), 32'hFFFF);  chk("R1 limit edge", xlViol, 0);
      xlate(2'(s), 32'h10000); chk("R1 beyond limit", xlViol, 1);
    end
  endtask

  task automatic t_real;
    loadReal(1, 16'h1234);
    xlate(1, 32'h5);
    chk("R2 selector", xlSel, 16'h1234);
    chk("R2 base x16", xlAddr, 32'h12345);
    chk("R2 access", xlAttr, 8'h93);
    xlate(1, 32'hFFFF);  chk("R6 real limit edge", xlViol, 0);
    xlate(1, 32'h10000); chk("R6 real viol", xlViol, 1);
    chk("R6 addr despite viol", xlAddr, 32'h22340);
  endtask

  task automatic t_prot;
    int n; logic [31:0] a0, a1;
    loadProt(2, 16'h0013, n, a0, a1);
    chk("R3 busy cycles", 32'(n), 3);
    chk("R3 low read addr", a0, 32'h50);
    chk("R3 high read addr", a1, 32'h54);
    xlate(2, 0);
    chk("R3 selector", xlSel, 16'h0013);
    chk("R4 base", xlAddr, 32'h12345678);
    chk("R4 access", xlAttr, 8'h9A);
    chk("R4 flags", xlFlags, 4'h4);
    xlate(2, 32'h123); chk("R6 byte limit edge", xlViol, 0);
    xlate(2, 32'h124); chk("R6 byte limit viol", xlViol, 1);
    chk("R6 addr wraps base+off", xlAddr, 32'h1234579C);
  endtask

  task automatic t_flat;
    int n; logic [31:0] a0, a1;
    loadProt(3, 16'h0008, n, a0, a1);
    loadProt(0, 16'h0018, n, a0, a1);
    xlate(0, 32'h2FFF); chk("R5 page limit edge", xlViol, 0);
    chk("R5 page base", xlAddr, 32'h3FFF);
    xlate(0, 32'h3000); chk("R5 page limit viol", xlViol, 1);
    @(negedge clk); protMode = 0;
    repeat (2) @(negedge clk);
    xlate(3, 32'hFFFF_FFF0);
    chk("R7 flat kept addr", xlAddr, 32'hFFFF_FFF0);
    chk("R5 flat no viol", xlViol, 0);
    chk("R7 selector kept", xlSel, 16'h0008);
    chk("R7 flags kept", xlFlags, 4'hC);
  endtask

  task automatic t_reload;
    loadReal(3, 16'h0008);
    xlate(3, 32'h10);
    chk("R8 same selector reload base", xlAddr, 32'h90);
    xlate(3, 32'h10000); chk("R8 limit back to 64K", xlViol, 1);
    chk("R8 flags cleared", xlFlags, 0);
  endtask

  task automatic t_err;
    logic [15:0] bad [3] = '{16'h0000, 16'h0020, 16'h000C};
    for (int k = 0; k < 3; k++) begin
      int rds = 0, errs = 0;
      @(negedge clk); protMode = 1; ldValid = 1; ldSeg = 1; ldSel = bad[k];
      @(negedge clk); ldValid = 0;
      if (ldErr) errs++;
      if (memRdEn || busy) rds++;
      @(negedge clk);
      if (ldErr) errs++;
      chk("R9 single error pulse", 32'(errs), 1);
      chk("R9 no fetch", 32'(rds), 0);
      xlate(1, 0);
      chk("R9 cache unchanged", xlAddr, 32'h12340);
      chk("R9 selector unchanged", xlSel, 16'h1234);
    end
  endtask

  task automatic t_mask_busy;
    int n; logic [31:0] a0, a1;
    tableBase = 32'h0100_0040;
    @(negedge clk); protMode = 1; ldValid = 1; ldSeg = 2; ldSel = 16'h0010;
    @(negedge clk); ldSeg = 1; ldSel = 16'h0008;  // R11: offered while busy
    chk("R10 masked table base", memAddr, 32'h50);
    @(negedge clk); ldValid = 0;
    repeat (3) @(negedge clk);
    xlate(1, 0);
    chk("R11 load while busy ignored", xlSel, 16'h1234);
    chk("R11 base unchanged", xlAddr, 32'h12340);
    xlate(2, 0);
    chk("R10 fetched via masked base", xlAddr, 32'h12345678);
    tableBase = 32'h40;
    loadProt(2, 16'h0010, n, a0, a1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[18] = 32'h0000FFFF; mem[19] = 32'h00CF9200;
    mem[20] = 32'h56780123; mem[21] = 32'h12409A34;
    mem[22] = 32'h10000002; mem[23] = 32'h00809200;
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset; t_real; t_prot; t_flat; t_reload; t_err; t_mask_busy;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule